// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Detector

This block watches the single tearing-effect line coming back from a display panel and sorts each pulse on it by width. Horizontal and vertical sync share the one pin. A pulse that lasts at least the vertical threshold is taken as a vertical sync. A shorter pulse that still reaches the horizontal threshold is taken as a horizontal sync. Anything shorter is ignored. Widths are measured in ticks of a shared clock-enable rather than in raw clock cycles, so the same thresholds hold whatever the divider ratio is.

After each vertical sync the block counts horizontal syncs as lines. When the programmed trigger condition is met, it drives a one-cycle active-low strobe on its match output. The trigger is either a chosen line number or every vertical sync. The falling edge of that strobe is used to launch a frame transfer toward the panel, so the new frame does not tear.

All configuration inputs are plain static levels. The block has no data stream, so there is no valid/ready interface and no back-pressure.

Top module: `te_sync_detect`

## Requirements
- R1: While `rst_n` is low, and after it is released with no pulse seen, `match_n` is high and the line count is zero.
- R2: The tearing-effect input passes through a two-flop synchronizer. A pulse's width is the number of cycles during which `tick` is high and the synchronized line is at its active level. With `tick` held low, no pulse ever qualifies.
- R3: The active level is the pin value XOR the inversion bit. `hs_inv` sets the active level used for horizontal measurement and `vs_inv` sets it for vertical measurement. An inversion bit of 0 means active-high.
- R4: A pulse is classified when it ends. It is a vertical sync if its width is at least (`vs_thr`+1)*8 ticks. Otherwise it is a horizontal sync if its width is at least `hs_thr`+1 ticks. Otherwise it is ignored.
- R5: No match is produced while `sync_en` is low, whatever the mode. Mode values 0 (off) and 1 (reserved) never produce a match.
- R6: A match is a single-cycle low pulse on `match_n`. It follows the end of the qualifying pulse on the synchronized line by at most a few cycles.
- R7: A vertical sync clears the line counter. In mode 3, every vertical sync produces one match.
- R8: A horizontal sync increments the line counter, which holds at its maximum value. In mode 2, a match fires whenever a sync event leaves the counter equal to `line_tgt`. With a target of 0, this means firing on vertical sync.
- R9: A pulse long enough to be a vertical sync is never also counted as a horizontal sync. It clears the line count and does not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_in | input | 1 | Asynchronous tearing-effect pin |
| tick | input | 1 | Width-measurement clock enable from the shared divider |
| sync_en | input | 1 | Global enable of the sync logic |
| mode | input | 2 | Trigger select: 0 off, 1 reserved, 2 line match, 3 vertical only |
| hs_thr | input | HS_W | Horizontal threshold in ticks minus one |
| vs_thr | input | VS_W | Vertical threshold in units of 8 ticks, minus one |
| hs_inv | input | 1 | Invert polarity for horizontal measurement |
| vs_inv | input | 1 | Invert polarity for vertical measurement |
| line_tgt | input | LINE_W | Target line for mode 2 |
| match_n | output | 1 | Active-low one-cycle match strobe |

## Verification
The end of a single long pulse is seen by both width channels in the same cycle, so horizontal and vertical classification collide there. The bench provokes this in mode 2 with a target of 1. It sends a vertical sync and a horizontal sync, which must match. It then sends a long pulse and another short one. A correct design clears the line count on the long pulse, so the short pulse that follows matches line 1 again. A design that also counted the long pulse as a line would miss that match. Alongside this, a sweep over every horizontal threshold and a range of pulse widths compares the match count against the width rule computed arithmetically.

// File: rtl/te_pkg.sv
package te_pkg;
  typedef enum logic [1:0] {
    TM_OFF   = 2'd0,
    TM_RSV   = 2'd1,
    TM_LINE  = 2'd2,
    TM_VSYNC = 2'd3
  } te_mode_e;

  typedef struct packed {
    logic hs;
    logic vs;
  } te_evt_t;
endpackage

// File: rtl/te_sync.sv
module te_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter
  import te_pkg::*;
#(
  parameter int HS_W  = 3,
  parameter int VS_W  = 12,
  localparam int CNT_W = VS_W + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            te_s,
  input  logic            tick,
  input  logic [HS_W-1:0] hs_thr,
  input  logic [VS_W-1:0] vs_thr,
  input  logic            hs_inv,
  input  logic            vs_inv,
  output te_evt_t         evt
);
  localparam int NCH = 2;  // channel 0 horizontal, 1 vertical

  logic [NCH-1:0]   inv;
  logic [NCH-1:0]   act;
  logic [NCH-1:0]   prev;
  logic [NCH-1:0]   ends;
  logic [CNT_W-1:0] width [NCH];

  logic [CNT_W-1:0] hs_ticks;
  logic [CNT_W-1:0] vs_ticks;

  assign inv      = {vs_inv, hs_inv};
  assign hs_ticks = CNT_W'(hs_thr) + CNT_W'(1);
  assign vs_ticks = CNT_W'((CNT_W'(vs_thr) + CNT_W'(1)) << 3);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign act[c]  = te_s ^ inv[c];
    assign ends[c] = prev[c] & ~act[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev[c]  <= 1'b0;
        width[c] <= '0;
      end else if (!en) begin
        prev[c]  <= 1'b0;
        width[c] <= '0;
      end else begin
        prev[c] <= act[c];
        if (!act[c])
          width[c] <= '0;
        else if (tick && width[c] != '1)
          width[c] <= width[c] + CNT_W'(1);
      end
    end
  end

  logic vs_hit, hs_hit;
  assign vs_hit = en && ends[1] && (width[1] >= vs_ticks);
  assign hs_hit = en && ends[0] && !vs_hit &&
                  (width[0] >= hs_ticks) && (width[0] < vs_ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= '{hs: hs_hit, vs: vs_hit};
  end

  a_r9_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.hs && evt.vs));
  a_r4_evt_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.hs || evt.vs) |-> $past(|prev));
  a_r2_width_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(act[1])) |-> width[1] == '0);
endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker
  import te_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  te_mode_e          mode,
  input  logic [LINE_W-1:0] line_tgt,
  input  te_evt_t           evt,
  output logic              match_n
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_q, line_nxt;
  logic              fire;

  always_comb begin
    line_nxt = line_q;
    if (evt.vs)
      line_nxt = '0;
    else if (evt.hs && line_q != LINE_MAX)
      line_nxt = line_q + LINE_W'(1);
  end

  always_comb begin
    fire = 1'b0;
    if (en) begin
      unique case (mode)
        TM_VSYNC: fire = evt.vs;
        TM_LINE:  fire = (evt.vs || evt.hs) && (line_nxt == line_tgt);
        default:  fire = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      match_n <= 1'b1;
    end else begin
      line_q  <= en ? line_nxt : '0;
      match_n <= ~fire;
    end
  end

  a_r7_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt.vs) |-> line_q == '0);
  a_r8_line_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(evt.hs) && !$past(evt.vs) && $past(line_q) != LINE_MAX)
      |-> line_q == $past(line_q) + LINE_W'(1));
  a_r6_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    !match_n |=> match_n);
  a_r5_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !match_n |-> $past(en));
endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
  import te_pkg::*;
#(
  parameter int HS_W   = 3,
  parameter int VS_W   = 12,
  parameter int LINE_W = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              te_in,
  input  logic              tick,
  input  logic              sync_en,
  input  logic [1:0]        mode,
  input  logic [HS_W-1:0]   hs_thr,
  input  logic [VS_W-1:0]   vs_thr,
  input  logic              hs_inv,
  input  logic              vs_inv,
  input  logic [LINE_W-1:0] line_tgt,
  output logic              match_n
);
  logic    te_s;
  te_evt_t evt;

  te_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(te_in), .q(te_s)
  );

  te_pulse_meter #(.HS_W(HS_W), .VS_W(VS_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .en(sync_en), .te_s(te_s), .tick(tick),
    .hs_thr(hs_thr), .vs_thr(vs_thr), .hs_inv(hs_inv), .vs_inv(vs_inv),
    .evt(evt)
  );

  te_line_tracker #(.LINE_W(LINE_W)) u_track (
    .clk(clk), .rst_n(rst_n), .en(sync_en), .mode(te_mode_e'(mode)),
    .line_tgt(line_tgt), .evt(evt), .match_n(match_n)
  );

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> match_n);
endmodule

// File: tb/test_te_sync_detect.sv
module test_te_sync_detect;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        te_in = 0;
  logic        tick = 1;
  logic        sync_en = 0;
  logic [1:0]  mode = 0;
  logic [2:0]  hs_thr = 0;
  logic [11:0] vs_thr = 0;
  logic        hs_inv = 0;
  logic        vs_inv = 0;
  logic [10:0] line_tgt = 0;
  logic        match_n;

  int n_chk = 0, n_fail = 0;
  int tdiv = 1, tph = 0;
  logic idle_lvl = 0;
  int mcnt = 0, run = 0, maxrun = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  te_sync_detect i_te_sync_detect (
    .clk(clk), .rst_n(rst_n), .te_in(te_in), .tick(tick), .sync_en(sync_en),
    .mode(mode), .hs_thr(hs_thr), .vs_thr(vs_thr), .hs_inv(hs_inv),
    .vs_inv(vs_inv), .line_tgt(line_tgt), .match_n(match_n)
  );

  always @(negedge clk) begin
    if (tdiv == 0) tick <= 0;
    else begin
      tick <= (tph == 0);
      tph  <= (tph + 1 >= tdiv) ? 0 : tph + 1;
    end
    if (!match_n) begin
      mcnt <= mcnt + 1;
      run  <= run + 1;
      if (run + 1 > maxrun) maxrun <= run + 1;
    end else run <= 0;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one pulse of w cycles at the active level, then an idle gap; returns matches seen
  task automatic send(int w, output int m);
    @(negedge clk); #1;
    mcnt = 0; maxrun = 0;
    te_in = ~idle_lvl;
    repeat (w) @(negedge clk);
    te_in = idle_lvl;
    repeat (12) @(negedge clk);
    #1;
    m = mcnt;
  endtask

  initial begin
    int m;
    #60000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int m;
    repeat (4) @(negedge clk);
    check("R1 match_n in reset", int'(match_n), 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 match_n after reset", int'(match_n), 1);
    sync_en = 1;

    // R4/R7 sweep in mode 3, R8 sweep in mode 2 with target 1
    for (int h = 0; h < 8; h++) begin
      hs_thr = 3'(h);
      for (int w = 1; w < 12; w++) begin
        mode = 2'd3;
        send(w, m);
        check("R4 R7 mode3 width sweep", m, (w >= 8) ? 1 : 0);
        mode = 2'd2; line_tgt = 11'd1;
        send(10, m);
        check("R7 vsync no line-1 match", m, 0);
        send(w, m);
        check("R4 R8 mode2 width sweep", m, (w < 8 && w >= h + 1) ? 1 : 0);
      end
    end

    // R6 single cycle strobe
    mode = 2'd3; hs_thr = 3'd1;
    send(9, m);
    check("R6 strobe width", maxrun, 1);

    // R4 larger vertical threshold boundary
    vs_thr = 12'd2;
    send(23, m); check("R4 vs below 24 ticks", m, 0);
    send(24, m); check("R4 vs at 24 ticks", m, 1);
    vs_thr = 12'd0;

    // R3 polarity
    hs_inv = 1; vs_inv = 1; idle_lvl = 1; te_in = 1;
    repeat (6) @(negedge clk);
    send(10, m); check("R3 inverted long low pulse", m, 1);
    send(5, m);  check("R3 inverted short pulse", m, 0);
    mode = 2'd2; line_tgt = 11'd1;
    send(10, m); send(4, m); check("R3 inverted hsync line 1", m, 1);
    hs_inv = 0; vs_inv = 0; idle_lvl = 0; te_in = 0;
    repeat (6) @(negedge clk);

    // R2 tick gating
    mode = 2'd3; tdiv = 4;
    send(32, m); check("R2 8 ticks over 32 cycles", m, 1);
    send(28, m); check("R2 7 ticks over 28 cycles", m, 0);
    tdiv = 0;
    send(40, m); check("R2 tick held low", m, 0);
    tdiv = 1;

    // R8 line target 3
    mode = 2'd2; line_tgt = 11'd3; hs_thr = 3'd1;
    send(10, m); check("R8 vs line 0", m, 0);
    send(3, m);  check("R8 line 1", m, 0);
    send(3, m);  check("R8 line 2", m, 0);
    send(3, m);  check("R8 line 3 match", m, 1);
    send(3, m);  check("R8 line 4", m, 0);
    line_tgt = 11'd0;
    send(10, m); check("R8 target 0 on vsync", m, 1);

    // R9 long pulse clears rather than increments
    line_tgt = 11'd1;
    send(10, m); send(3, m); check("R9 first line 1", m, 1);
    send(10, m); check("R9 long pulse no match", m, 0);
    send(3, m);  check("R9 line 1 again", m, 1);

    // R5 enable and mode gating
    mode = 2'd3; sync_en = 0;
    send(10, m); check("R5 sync_en low", m, 0);
    sync_en = 1; mode = 2'd0;
    send(10, m); check("R5 mode 0", m, 0);
    mode = 2'd1;
    send(10, m); check("R5 mode 1", m, 0);
    mode = 2'd3;
    send(10, m); check("R5 re-enabled", m, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule